// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block sits between a CPU-side register port and the erase interface of an on-chip flash array. Software arms an erase by first loading a page number or setting a mass-erase enable bit. It then writes a command byte. The byte `0x55` asks for a page erase and `0xAA` asks for a whole-array erase. Every other byte value is dropped.

The sequencer checks the arming state and the debug-port enable input. When the checks pass, it raises a single-cycle request towards the flash macro, carrying either the page number or a mass flag. It then holds `busy` until the macro returns a done strobe. The arming for an erase is used up by the request it launches. A leftover arming value can therefore never start a second erase.

The controller has three named states:
- **ST_IDLE**: waits for an accepted command. An accepted page command takes the transition *launch_page* to ST_REQ. An accepted mass command takes *launch_mass* to ST_REQ.
- **ST_REQ**: drives the request for one cycle, then takes *issued* to ST_WAIT.
- **ST_WAIT**: holds busy. It takes *done* back to ST_IDLE when `flash_done` is seen, and otherwise stays (*hold*).

Top module: `erase_seq_top`

## Requirements
- R1: After reset, `busy`, `req_page` and `req_mass` are all low.
- R2: A write of `0x55` to the command select (`reg_sel`=0) while idle, with a page armed, drives `req_page` high for exactly one cycle, in the cycle after the write. `req_addr` carries the armed page and `req_mass` stays low. A page is armed by a write to `reg_sel`=1. Only bits 5:0 of that write are kept, as page 0 to 63.
- R3: A write of `0xAA` to the command select while idle drives `req_mass` high for exactly one cycle, in the cycle after the write, with `req_page` low. This needs the mass-erase enable bit to be set (bit 0 of a write to `reg_sel`=2) and `dbg_en` to be high.
- R4: A command byte other than `0x55` or `0xAA` starts no request, sets no busy, and leaves the arming state unchanged.
- R5: A `0x55` command with no page armed (including straight after reset) starts nothing.
- R6: A `0xAA` command starts nothing if the enable bit is clear or `dbg_en` is low. A refused command leaves the arming state as it was.
- R7: Launching a page erase disarms the page, and launching a mass erase clears the enable bit. A repeated command of the same type without re-arming starts nothing.
- R8: `busy` is high from the request cycle until the cycle after `flash_done` is seen while waiting. It then falls and the block accepts commands again.
- R9: Command writes made while `busy` is high are ignored, and they consume no arming. Arming writes made while busy are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 page number, 2 mass enable, 3 unused |
| reg_wdata | input | 8 | Write data |
| dbg_en | input | 1 | Debug-port enable, required for mass erase |
| flash_done | input | 1 | Erase-complete strobe from the flash macro |
| req_page | output | 1 | One-cycle page-erase request |
| req_mass | output | 1 | One-cycle mass-erase request |
| req_addr | output | 6 | Page number sent with the request |
| busy | output | 1 | Erase in progress |

## Verification
The hardest case to reach from the ports is a command that arrives while an erase is still in flight, paired with fresh arming written in the same window. The bench reaches it by holding `flash_done` low so the block stays in ST_WAIT. During that window it writes a new page number and then a `0x55` command. After the done strobe, a bare `0x55` must launch a request for that page. This shows that the arming write was kept and that the ignored command did not consume it.

// File: rtl/erase_pkg.sv
package erase_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_t;

    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_PAGE = 2'd1;
    localparam logic [1:0] SEL_MASS = 2'd2;

    localparam logic [7:0] CMD_PAGE_ERASE = 8'h55;
    localparam logic [7:0] CMD_MASS_ERASE = 8'hAA;
endpackage

// File: rtl/erase_arm_regs.sv
module erase_arm_regs #(
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_page,
    input  logic [PAGE_W-1:0] page_data,
    input  logic              wr_mass,
    input  logic              mass_bit,
    input  logic              use_page,
    input  logic              use_mass,
    output logic [PAGE_W-1:0] page_addr,
    output logic              page_armed,
    output logic              mass_en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_addr  <= '0;
            page_armed <= 1'b0;
        end else if (wr_page) begin
            page_addr  <= page_data;
            page_armed <= 1'b1;
        end else if (use_page) begin
            page_armed <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mass_en <= 1'b0;
        end else if (wr_mass) begin
            mass_en <= mass_bit;
        end else if (use_mass) begin
            mass_en <= 1'b0;
        end
    end
endmodule

// File: rtl/erase_cmd_decode.sv
module erase_cmd_decode
    import erase_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_byte,
    input  logic              idle,
    input  logic              page_armed,
    input  logic              mass_en,
    input  logic              dbg_en,
    output logic              go_page,
    output logic              go_mass
);
    localparam logic [DATA_W-1:0] PAGE_CODE = DATA_W'(CMD_PAGE_ERASE);
    localparam logic [DATA_W-1:0] MASS_CODE = DATA_W'(CMD_MASS_ERASE);

    logic accept;
    assign accept = cmd_wr && idle;

    always_comb begin
        go_page = 1'b0;
        go_mass = 1'b0;
        if (accept) begin
            if (cmd_byte == PAGE_CODE) begin
                go_page = page_armed;
            end else if (cmd_byte == MASS_CODE) begin
                go_mass = mass_en && dbg_en;
            end
        end
    end
endmodule

// File: rtl/erase_seq_fsm.sv
module erase_seq_fsm
    import erase_pkg::*;
#(
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_page,
    input  logic              go_mass,
    input  logic              flash_done,
    input  logic [PAGE_W-1:0] page_addr,
    output logic              idle,
    output logic              req_page,
    output logic              req_mass,
    output logic [PAGE_W-1:0] req_addr,
    output logic              busy
);
    seq_state_t state_q, state_d;
    logic              kind_mass_q;
    logic [PAGE_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            kind_mass_q <= 1'b0;
            addr_q      <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && (go_page || go_mass)) begin
                kind_mass_q <= go_mass;
                addr_q      <= go_page ? page_addr : '0;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go_page || go_mass) state_d = ST_REQ;  // launch_page / launch_mass
            ST_REQ:  state_d = ST_WAIT;                          // issued
            ST_WAIT: if (flash_done) state_d = ST_IDLE;          // done / hold
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        idle     = 1'b0;
        req_page = 1'b0;
        req_mass = 1'b0;
        busy     = 1'b0;
        req_addr = addr_q;
        unique case (state_q)
            ST_IDLE: idle = 1'b1;
            ST_REQ: begin
                busy     = 1'b1;
                req_page = !kind_mass_q;
                req_mass = kind_mass_q;
            end
            ST_WAIT: busy = 1'b1;
            default: idle = 1'b1;
        endcase
    end
endmodule

// File: rtl/erase_seq_top.sv
module erase_seq_top
    import erase_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              dbg_en,
    input  logic              flash_done,
    output logic              req_page,
    output logic              req_mass,
    output logic [PAGE_W-1:0] req_addr,
    output logic              busy
);
    logic wr_cmd, wr_page, wr_mass;
    logic go_page, go_mass, idle;
    logic page_armed, mass_en;
    logic [PAGE_W-1:0] page_addr;

    assign wr_cmd  = reg_we && (reg_sel == SEL_CMD);
    assign wr_page = reg_we && (reg_sel == SEL_PAGE);
    assign wr_mass = reg_we && (reg_sel == SEL_MASS);

    erase_arm_regs #(.PAGE_W(PAGE_W)) u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_page    (wr_page),
        .page_data  (reg_wdata[PAGE_W-1:0]),
        .wr_mass    (wr_mass),
        .mass_bit   (reg_wdata[0]),
        .use_page   (go_page),
        .use_mass   (go_mass),
        .page_addr  (page_addr),
        .page_armed (page_armed),
        .mass_en    (mass_en)
    );

    erase_cmd_decode #(.DATA_W(DATA_W)) u_dec (
        .cmd_wr     (wr_cmd),
        .cmd_byte   (reg_wdata),
        .idle       (idle),
        .page_armed (page_armed),
        .mass_en    (mass_en),
        .dbg_en     (dbg_en),
        .go_page    (go_page),
        .go_mass    (go_mass)
    );

    erase_seq_fsm #(.PAGE_W(PAGE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_page    (go_page),
        .go_mass    (go_mass),
        .flash_done (flash_done),
        .page_addr  (page_addr),
        .idle       (idle),
        .req_page   (req_page),
        .req_mass   (req_mass),
        .req_addr   (req_addr),
        .busy       (busy)
    );
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk #(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_sel,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              dbg_en,
    input logic              flash_done,
    input logic              req_page,
    input logic              req_mass,
    input logic [PAGE_W-1:0] req_addr,
    input logic              busy
);
    p_req_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_page && req_mass));

    p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_page || req_mass) |=> !(req_page || req_mass));

    p_req_after_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_mass |-> ($past(reg_we) && $past(reg_sel) == 2'd0 && $past(reg_wdata) == DATA_W'(8'hAA)));

    p_mass_dbg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_mass |-> $past(dbg_en));

    p_req_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_page || req_mass) |-> busy);

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !flash_done) |=> busy);

    p_busy_cmd_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_sel == 2'd0) |=> !(req_page || req_mass));

    p_page_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(req_addr));
endmodule

bind erase_seq_top erase_seq_chk #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .dbg_en     (dbg_en),
    .flash_done (flash_done),
    .req_page   (req_page),
    .req_mass   (req_mass),
    .req_addr   (req_addr),
    .busy       (busy)
);

// File: tb/test_erase_seq_top.sv
module test_erase_seq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic       dbg_en = 1'b0;
    logic       flash_done = 1'b0;
    logic       req_page, req_mass, busy;
    logic [5:0] req_addr;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    erase_seq_top i_erase_seq_top (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .dbg_en(dbg_en), .flash_done(flash_done),
        .req_page(req_page), .req_mass(req_mass), .req_addr(req_addr), .busy(busy)
    );

    // fields: [18:17] sel, [16:9] data, [8] dbg_en, [7] exp page, [6] exp mass, [5:0] exp addr
    localparam int NV = 16;
    localparam logic [18:0] VEC [NV] = '{
        {2'd0, 8'h55, 1'b1, 1'b0, 1'b0, 6'd0},   // R5 unarmed after reset
        {2'd0, 8'hAA, 1'b1, 1'b0, 1'b0, 6'd0},   // R6 enable clear
        {2'd1, 8'h2A, 1'b0, 1'b0, 1'b0, 6'd0},   // arm page 42
        {2'd0, 8'h33, 1'b0, 1'b0, 1'b0, 6'd0},   // R4 junk byte
        {2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 6'd0},   // R4 zero byte
        {2'd0, 8'h55, 1'b0, 1'b1, 1'b0, 6'd42},  // R2 page erase
        {2'd0, 8'h55, 1'b0, 1'b0, 1'b0, 6'd0},   // R7 page consumed
        {2'd2, 8'h01, 1'b0, 1'b0, 1'b0, 6'd0},   // arm mass
        {2'd0, 8'hAA, 1'b0, 1'b0, 1'b0, 6'd0},   // R6 dbg low
        {2'd0, 8'hAA, 1'b1, 1'b0, 1'b1, 6'd0},   // R3 mass erase
        {2'd0, 8'hAA, 1'b1, 1'b0, 1'b0, 6'd0},   // R7 mass consumed
        {2'd1, 8'hFF, 1'b1, 1'b0, 1'b0, 6'd0},   // arm page, bits 7:6 dropped
        {2'd0, 8'hAB, 1'b1, 1'b0, 1'b0, 6'd0},   // R4 near-miss byte
        {2'd0, 8'h55, 1'b1, 1'b1, 1'b0, 6'd63},  // R2 page 63
        {2'd1, 8'h00, 1'b1, 1'b0, 1'b0, 6'd0},   // arm page 0
        {2'd0, 8'h55, 1'b1, 1'b1, 1'b0, 6'd0}    // R2 page 0
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // write on one edge; returns at the following negedge, where the response is visible
    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // from the request cycle: check one-cycle pulse, then finish the erase
    task automatic finish_erase(input string req);
        @(negedge clk);
        check(!req_page && !req_mass && busy, req, {req_page, req_mass, busy}, 3'b001);
        flash_done = 1'b1;
        @(negedge clk);
        flash_done = 1'b0;
        check(!busy, "R8", busy, 0);
    endtask

    initial begin
        #20000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !req_page && !req_mass, "R1", {busy, req_page, req_mass}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !req_page && !req_mass, "R1", {busy, req_page, req_mass}, 0);

        for (int i = 0; i < NV; i++) begin
            dbg_en = VEC[i][8];
            wr(VEC[i][18:17], VEC[i][16:9]);
            check(req_page == VEC[i][7] && req_mass == VEC[i][6], "R2/R3 vector",
                  {req_page, req_mass}, {VEC[i][7], VEC[i][6]});
            if (VEC[i][7]) check(req_addr == VEC[i][5:0], "R2 addr", req_addr, VEC[i][5:0]);
            if (VEC[i][7] || VEC[i][6]) begin
                check(busy, "R8", busy, 1);
                finish_erase("R2 one-cycle");
            end else begin
                check(!busy, "R4", busy, 0);
            end
        end

        // R8 busy held while done stays low; R9 commands during busy ignored
        wr(2'd1, 8'd9);
        wr(2'd0, 8'h55);
        check(req_page && req_addr == 6'd9, "R2", req_addr, 9);
        repeat (5) @(negedge clk);
        check(busy, "R8", busy, 1);
        wr(2'd1, 8'd7);
        wr(2'd0, 8'h55);
        check(!req_page && !req_mass && busy, "R9", {req_page, req_mass}, 0);
        @(negedge clk);
        check(!req_page && busy, "R9", req_page, 0);
        flash_done = 1'b1;
        @(negedge clk);
        flash_done = 1'b0;
        check(!busy, "R8", busy, 0);
        wr(2'd0, 8'h55);
        check(req_page && req_addr == 6'd7, "R9 arming kept", req_addr, 7);
        finish_erase("R2");

        // R6 mass with dbg low keeps enable; later succeeds
        dbg_en = 1'b0;
        wr(2'd2, 8'h01);
        wr(2'd0, 8'hAA);
        check(!req_mass, "R6", req_mass, 0);
        dbg_en = 1'b1;
        wr(2'd0, 8'hAA);
        check(req_mass && !req_page, "R6 arming kept", req_mass, 1);
        finish_erase("R3");

        // R7 clearing the enable by writing 0 blocks mass erase
        wr(2'd2, 8'h01);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'hAA);
        check(!req_mass && !busy, "R7", req_mass, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule